// File: doc/BRIEF.md
# Clock-Crossing Mailbox Channel

This block is a one-way mailbox that carries a flag word from a sender to a receiver running on unrelated clocks. The sender ORs bits into the channel or removes them through two write-only mask registers. The receiver reads the channel directly and clears bits with a mask write. The receiver interrupt is high whenever any channel bit is set. The channel can carry a single word, or up to WIDTH independent one-bit messages. A doorbell is a single set bit whose only job is to raise the interrupt. A full-duplex link uses two instances, one for each direction.

Every sender update crosses the clock boundary through a toggle request/acknowledge handshake. Each direction has a multi-flop synchronizer. While a transfer is in flight, further sender writes are folded into a pending pair of masks, so that no update is dropped. A synchronized copy of the receiver's "channel empty" state comes back to the sender. There it drives a status bit and a sticky "drained" flag. The flag can raise a sender interrupt once the receiver has cleared everything that was sent.

Top module: `mhu_mailbox`

## Requirements
- R1: After reset the channel reads 0, both interrupts are low, and the sender status reads 1: status bit 0 is empty, bit 1 is pending, bit 2 is drained and bit 3 is interrupt-enable.
- R2: A sender write to address 0 (set) ORs the write data into the channel. Once the sender's pending bit is low, the receiver read data shows the OR, and the receiver interrupt is high exactly when the channel is non-zero.
- R3: A sender write to address 1 (clear) removes the bits of the write data from the channel.
- R4: A receiver write clears the bits of its write data, and the result is visible in the next receiver clock cycle.
- R5: If a sender set and a receiver clear of the same bit take effect in the same receiver cycle, the set wins, so a doorbell is never lost.
- R6: Set and clear writes made while a transfer is in flight are merged in order into one later update. A bit set and then cleared ends cleared, a bit cleared and then set ends set, and no bit is lost.
- R7: The pending status bit is high from the cycle after a set or clear write with a non-zero mask until that update has been applied and acknowledged. The empty status bit reports the receiver's channel state once nothing is pending.
- R8: The drained flag sets when the channel is seen empty after a set update was sent. A write to address 2 with bit 1 high clears the flag. The sender interrupt equals the drained flag gated by the enable bit 0 of address 2.
- R9: A write to address 3 (status) changes nothing, and a clear write with a zero mask starts no transfer.
- R10: Any WIDTH-bit word passes through the channel unchanged. This holds for every single-bit position and for full-word patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Sender clock |
| s_rst_n | input | 1 | Sender asynchronous reset, active low |
| s_wr | input | 1 | Sender register write strobe |
| s_addr | input | 2 | Sender register address: 0 set, 1 clear, 2 control, 3 status |
| s_wdata | input | WIDTH | Sender write data |
| s_rdata | output | WIDTH | Sender read data: control at address 2, status at address 3, zero otherwise |
| s_irq | output | 1 | Sender interrupt: channel drained |
| r_clk | input | 1 | Receiver clock |
| r_rst_n | input | 1 | Receiver asynchronous reset, active low |
| r_wr | input | 1 | Receiver clear strobe |
| r_wdata | input | WIDTH | Receiver clear mask |
| r_rdata | output | WIDTH | Current channel value |
| r_irq | output | 1 | Receiver interrupt: channel non-zero |

## Verification
The bench walks a single set bit across every position and then pushes full-word patterns. A crossing that skewed or sampled the masks before they were stable would deliver a corrupted word. It fires set and clear writes on consecutive sender cycles. A design without merging would drop the later writes, and one that merged out of order would leave a bit in the wrong state. It holds a receiver clear on a bit while the sender rings that same bit. If the receiver clear won the tie, the bit would never be seen high. It also checks the drained flag with the interrupt both enabled and disabled. A design that trusted a stale empty indication would raise the flag while bits were still set.

// File: rtl/mhu_pkg.sv
package mhu_pkg;
  typedef enum logic [1:0] {
    MHU_A_SET  = 2'd0,
    MHU_A_CLR  = 2'd1,
    MHU_A_CTRL = 2'd2,
    MHU_A_STAT = 2'd3
  } mhu_addr_e;

  localparam int ST_EMPTY = 0;
  localparam int ST_PEND  = 1;
  localparam int ST_DONE  = 2;
  localparam int ST_IRQEN = 3;

  localparam int CT_IRQEN   = 0;
  localparam int CT_DONECLR = 1;
endpackage

// File: rtl/mhu_sync.sv
module mhu_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mhu_tx.sv
module mhu_tx
  import mhu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             irq,
  input  logic             ack_sync,
  input  logic             empty_sync,
  output logic             req_tgl,
  output logic [WIDTH-1:0] launch_set,
  output logic [WIDTH-1:0] launch_clr,
  output logic             busy_o,
  output logic             pending_o,
  output logic             done_o,
  output logic             irq_en_o
);
  // Ordered merge: a later write overrides any earlier opposite request.
  function automatic logic [WIDTH-1:0] fold_mask(input logic [WIDTH-1:0] held,
                                                 input logic [WIDTH-1:0] cancel,
                                                 input logic [WIDTH-1:0] add);
    return (held & ~cancel) | add;
  endfunction

  logic [WIDTH-1:0] pend_set_q, pend_clr_q;
  logic [WIDTH-1:0] wr_set, wr_clr, m_set, m_clr;
  logic             busy, busy_d, launch, empty_view, empty_d, rise;
  logic             sent_q, sent_n, done_q, irq_en_q, done_clr;

  always_comb begin
    wr_set   = (wr && addr == MHU_A_SET) ? wdata : '0;
    wr_clr   = (wr && addr == MHU_A_CLR) ? wdata : '0;
    m_set    = fold_mask(pend_set_q, wr_clr, wr_set);
    m_clr    = fold_mask(pend_clr_q, wr_set, wr_clr);
    busy     = (req_tgl != ack_sync);
    launch   = !busy && ((m_set | m_clr) != '0);
    empty_view = empty_sync && !busy && !busy_d &&
                 (pend_set_q == '0) && (pend_clr_q == '0);
    rise     = empty_view && !empty_d;
    sent_n   = (sent_q && !rise) || (launch && (m_set != '0));
    done_clr = wr && addr == MHU_A_CTRL && wdata[CT_DONECLR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_set_q <= '0;
      pend_clr_q <= '0;
      launch_set <= '0;
      launch_clr <= '0;
      req_tgl    <= 1'b0;
      busy_d     <= 1'b0;
      empty_d    <= 1'b1;
      sent_q     <= 1'b0;
      done_q     <= 1'b0;
      irq_en_q   <= 1'b0;
    end else begin
      busy_d  <= busy;
      empty_d <= empty_view;
      sent_q  <= sent_n;
      if (launch) begin
        launch_set <= m_set;
        launch_clr <= m_clr;
        req_tgl    <= ~req_tgl;
        pend_set_q <= '0;
        pend_clr_q <= '0;
      end else begin
        pend_set_q <= m_set;
        pend_clr_q <= m_clr;
      end
      if (done_clr)             done_q <= 1'b0;
      else if (rise && sent_q)  done_q <= 1'b1;
      if (wr && addr == MHU_A_CTRL) irq_en_q <= wdata[CT_IRQEN];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      MHU_A_CTRL: rdata[CT_IRQEN] = irq_en_q;
      MHU_A_STAT: begin
        rdata[ST_EMPTY] = empty_view;
        rdata[ST_PEND]  = pending_o;
        rdata[ST_DONE]  = done_q;
        rdata[ST_IRQEN] = irq_en_q;
      end
      default: rdata = '0;
    endcase
  end

  assign pending_o = busy || (pend_set_q != '0) || (pend_clr_q != '0);
  assign busy_o    = busy;
  assign done_o    = done_q;
  assign irq_en_o  = irq_en_q;
  assign irq       = done_q && irq_en_q;
endmodule

// File: rtl/mhu_rx.sv
module mhu_rx #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             req_sync,
  input  logic [WIDTH-1:0] launch_set,
  input  logic [WIDTH-1:0] launch_clr,
  output logic             ack_tgl,
  output logic             empty_q,
  output logic [WIDTH-1:0] chan,
  output logic             apply_o,
  output logic [WIDTH-1:0] set_in_o
);
  // Receiver clear first, then sender update: a sender set always survives.
  function automatic logic [WIDTH-1:0] next_chan(input logic [WIDTH-1:0] cur,
                                                 input logic [WIDTH-1:0] rclr,
                                                 input logic [WIDTH-1:0] sclr,
                                                 input logic [WIDTH-1:0] sset);
    return ((cur & ~rclr) & ~sclr) | sset;
  endfunction

  logic             apply;
  logic [WIDTH-1:0] set_in, clr_in, rclr, chan_n;

  always_comb begin
    apply  = (req_sync != ack_tgl);
    set_in = apply ? launch_set : '0;
    clr_in = apply ? launch_clr : '0;
    rclr   = wr ? wdata : '0;
    chan_n = next_chan(chan, rclr, clr_in, set_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan    <= '0;
      ack_tgl <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      chan    <= chan_n;
      empty_q <= (chan_n == '0);
      if (apply) ack_tgl <= req_sync;
    end
  end

  assign apply_o  = apply;
  assign set_in_o = set_in;
endmodule

// File: rtl/mhu_mailbox.sv
module mhu_mailbox #(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             s_clk,
  input  logic             s_rst_n,
  input  logic             s_wr,
  input  logic [1:0]       s_addr,
  input  logic [WIDTH-1:0] s_wdata,
  output logic [WIDTH-1:0] s_rdata,
  output logic             s_irq,
  input  logic             r_clk,
  input  logic             r_rst_n,
  input  logic             r_wr,
  input  logic [WIDTH-1:0] r_wdata,
  output logic [WIDTH-1:0] r_rdata,
  output logic             r_irq
);
  logic             req_tgl, req_at_r, ack_tgl, ack_at_s, r_empty, empty_at_s;
  logic [WIDTH-1:0] launch_set, launch_clr, rx_set_in;
  logic             tx_busy, tx_pending, tx_done, tx_irq_en, rx_apply;

  mhu_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_req_sync (
    .clk(r_clk), .rst_n(r_rst_n), .d(req_tgl), .q(req_at_r));
  mhu_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_ack_sync (
    .clk(s_clk), .rst_n(s_rst_n), .d(ack_tgl), .q(ack_at_s));
  mhu_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_empty_sync (
    .clk(s_clk), .rst_n(s_rst_n), .d(r_empty), .q(empty_at_s));

  mhu_tx #(.WIDTH(WIDTH)) u_tx (
    .clk(s_clk), .rst_n(s_rst_n), .wr(s_wr), .addr(s_addr), .wdata(s_wdata),
    .rdata(s_rdata), .irq(s_irq), .ack_sync(ack_at_s), .empty_sync(empty_at_s),
    .req_tgl(req_tgl), .launch_set(launch_set), .launch_clr(launch_clr),
    .busy_o(tx_busy), .pending_o(tx_pending), .done_o(tx_done),
    .irq_en_o(tx_irq_en));

  mhu_rx #(.WIDTH(WIDTH)) u_rx (
    .clk(r_clk), .rst_n(r_rst_n), .wr(r_wr), .wdata(r_wdata),
    .req_sync(req_at_r), .launch_set(launch_set), .launch_clr(launch_clr),
    .ack_tgl(ack_tgl), .empty_q(r_empty), .chan(r_rdata),
    .apply_o(rx_apply), .set_in_o(rx_set_in));

  assign r_irq = (r_rdata != '0);
endmodule

// File: rtl/mhu_mailbox_chk.sv
module mhu_mailbox_chk #(
  parameter int WIDTH = 32
) (
  input logic             s_clk,
  input logic             s_rst_n,
  input logic             s_wr,
  input logic [1:0]       s_addr,
  input logic [WIDTH-1:0] s_wdata,
  input logic             s_irq,
  input logic             r_clk,
  input logic             r_rst_n,
  input logic             r_wr,
  input logic [WIDTH-1:0] r_wdata,
  input logic [WIDTH-1:0] r_rdata,
  input logic             r_irq,
  input logic             tx_busy,
  input logic             tx_pending,
  input logic             tx_done,
  input logic             tx_irq_en,
  input logic [WIDTH-1:0] launch_set,
  input logic [WIDTH-1:0] launch_clr,
  input logic             rx_apply,
  input logic [WIDTH-1:0] rx_set_in
);
  assert_rx_clear_R4: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    (r_wr && !rx_apply) |=> ((r_rdata & $past(r_wdata)) == '0));

  assert_set_wins_R5: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    rx_apply |=> ((r_rdata & $past(rx_set_in)) == $past(rx_set_in)));

  assert_launch_stable_R6: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    (tx_busy && $past(tx_busy)) |-> ($stable(launch_set) && $stable(launch_clr)));

  assert_pending_R7: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    (s_wr && (s_addr == 2'd0 || s_addr == 2'd1) && s_wdata != '0) |=> tx_pending);

  assert_done_idle_R8: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    $rose(tx_done) |-> !tx_busy);

  assert_irq_gate_R8: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    s_irq |-> (tx_irq_en && tx_done));

  assert_rirq_R2: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    $rose(r_irq) |-> $past(rx_apply));
endmodule

bind mhu_mailbox mhu_mailbox_chk #(.WIDTH(WIDTH)) u_chk (
  .s_clk(s_clk), .s_rst_n(s_rst_n), .s_wr(s_wr), .s_addr(s_addr),
  .s_wdata(s_wdata), .s_irq(s_irq), .r_clk(r_clk), .r_rst_n(r_rst_n),
  .r_wr(r_wr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq(r_irq),
  .tx_busy(tx_busy), .tx_pending(tx_pending), .tx_done(tx_done),
  .tx_irq_en(tx_irq_en), .launch_set(launch_set), .launch_clr(launch_clr),
  .rx_apply(rx_apply), .rx_set_in(rx_set_in));

// File: tb/tb_mhu_mailbox.sv
`timescale 1ns/100ps
module tb_mhu_mailbox;
  localparam int W = 32;

  logic         s_clk = 1'b0, r_clk = 1'b0;
  logic         s_rst_n = 1'b0, r_rst_n = 1'b0;
  logic         s_wr = 1'b0;
  logic [1:0]   s_addr = 2'd3;
  logic [W-1:0] s_wdata = '0;
  logic [W-1:0] s_rdata;
  logic         s_irq;
  logic         r_wr = 1'b0;
  logic [W-1:0] r_wdata = '0;
  logic [W-1:0] r_rdata;
  logic         r_irq;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #4   s_clk = ~s_clk;
  always #5.5 r_clk = ~r_clk;

  mhu_mailbox #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .s_clk(s_clk), .s_rst_n(s_rst_n), .s_wr(s_wr), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_rdata(s_rdata), .s_irq(s_irq),
    .r_clk(r_clk), .r_rst_n(r_rst_n), .r_wr(r_wr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_irq(r_irq));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic s_write(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge s_clk);
    s_wr = 1'b1; s_addr = a; s_wdata = d;
    @(negedge s_clk);
    s_wr = 1'b0; s_addr = 2'd3; s_wdata = '0;
  endtask

  task automatic s_read(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge s_clk);
    s_addr = a;
    #1 d = s_rdata;
    s_addr = 2'd3;
  endtask

  task automatic wait_idle();
    logic [W-1:0] st;
    for (int i = 0; i < 400; i++) begin
      s_read(2'd3, st);
      if (!st[1]) break;
    end
    repeat (8) @(negedge s_clk);
  endtask

  task automatic r_clear(input logic [W-1:0] m);
    @(negedge r_clk);
    r_wr = 1'b1; r_wdata = m;
    @(negedge r_clk);
    r_wr = 1'b0; r_wdata = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge s_clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] st, pat;
    bit saw;
    repeat (3) @(negedge s_clk);
    s_rst_n = 1'b1; r_rst_n = 1'b1;
    repeat (4) @(negedge s_clk);

    // R1 reset state
    check("R1 chan", r_rdata, '0);
    check("R1 r_irq", {31'b0, r_irq}, 0);
    check("R1 s_irq", {31'b0, s_irq}, 0);
    s_read(2'd3, st);
    check("R1 status", st, 32'h1);

    // R7 pending right after write, R2 set delivered
    s_write(2'd0, 32'h1);
    #1 st = s_rdata;
    check("R7 pending", {30'b0, st[1:0]}, 32'h2);
    wait_idle();
    check("R2 set", r_rdata, 32'h1);
    check("R2 r_irq high", {31'b0, r_irq}, 1);
    s_read(2'd3, st);
    check("R7 empty low", {31'b0, st[0]}, 0);
    s_write(2'd0, 32'h8000_0000);
    wait_idle();
    check("R2 or", r_rdata, 32'h8000_0001);

    // R3 sender clear
    s_write(2'd1, 32'h8000_0001);
    wait_idle();
    check("R3 clear", r_rdata, '0);
    check("R2 r_irq low", {31'b0, r_irq}, 0);
    s_read(2'd3, st);
    check("R7 empty high", {31'b0, st[0]}, 1);

    // R10 walking bit sweep and word patterns
    for (int i = 0; i < W; i++) begin
      s_write(2'd0, 32'h1 << i);
      wait_idle();
      check($sformatf("R10 bit%0d", i), r_rdata, 32'h1 << i);
      r_clear(32'h1 << i);
      check($sformatf("R4 bit%0d", i), r_rdata, '0);
    end
    for (int k = 1; k <= 8; k++) begin
      pat = k * 32'h9E37_79B9;
      s_write(2'd0, pat);
      wait_idle();
      check($sformatf("R10 word%0d", k), r_rdata, pat);
      r_clear(32'hFFFF_FFFF);
      check("R4 full clear", r_rdata, '0);
    end

    // R4 partial receiver clear
    s_write(2'd0, 32'h0000_F0F0);
    wait_idle();
    r_clear(32'h0000_0030);
    check("R4 partial", r_rdata, 32'h0000_F0C0);
    r_clear(32'hFFFF_FFFF);

    // R6 back-to-back merging
    @(negedge s_clk);
    s_wr = 1'b1; s_addr = 2'd0; s_wdata = 32'h1;
    @(negedge s_clk); s_wdata = 32'h2;
    @(negedge s_clk); s_wdata = 32'h4;
    @(negedge s_clk); s_addr = 2'd1; s_wdata = 32'h4;
    @(negedge s_clk); s_wr = 1'b0; s_addr = 2'd3; s_wdata = '0;
    wait_idle();
    check("R6 set-then-clear", r_rdata, 32'h3);
    @(negedge s_clk);
    s_wr = 1'b1; s_addr = 2'd1; s_wdata = 32'h3;
    @(negedge s_clk); s_addr = 2'd0; s_wdata = 32'h1;
    @(negedge s_clk); s_wr = 1'b0; s_addr = 2'd3; s_wdata = '0;
    wait_idle();
    check("R6 clear-then-set", r_rdata, 32'h1);

    // R9 ignored writes
    s_write(2'd3, 32'hFFFF_FFFF);
    repeat (20) @(negedge s_clk);
    check("R9 status write chan", r_rdata, 32'h1);
    s_read(2'd2, st);
    check("R9 status write ctrl", st, '0);
    s_write(2'd1, 32'h0);
    #1 st = s_rdata;
    check("R9 zero clear no pending", {31'b0, st[1]}, 0);
    r_clear(32'hFFFF_FFFF);
    repeat (10) @(negedge s_clk);

    // R8 drained flag and interrupt
    s_write(2'd2, 32'h2);
    s_write(2'd2, 32'h1);
    s_write(2'd0, 32'h8);
    wait_idle();
    s_read(2'd3, st);
    check("R8 no done while set", {31'b0, st[2]}, 0);
    check("R8 s_irq low while set", {31'b0, s_irq}, 0);
    r_clear(32'h8);
    repeat (12) @(negedge s_clk);
    s_read(2'd3, st);
    check("R8 done", {31'b0, st[2]}, 1);
    check("R8 s_irq", {31'b0, s_irq}, 1);
    s_write(2'd2, 32'h3);
    #1;
    check("R8 done cleared irq", {31'b0, s_irq}, 0);
    s_read(2'd3, st);
    check("R8 done cleared", {31'b0, st[2]}, 0);
    s_write(2'd2, 32'h0);
    s_write(2'd0, 32'h8);
    wait_idle();
    r_clear(32'h8);
    repeat (12) @(negedge s_clk);
    s_read(2'd3, st);
    check("R8 done masked", {31'b0, st[2]}, 1);
    check("R8 irq masked", {31'b0, s_irq}, 0);

    // R5 set wins over a simultaneous receiver clear
    @(negedge r_clk);
    r_wr = 1'b1; r_wdata = 32'h10;
    s_write(2'd0, 32'h10);
    saw = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge r_clk);
      if (r_rdata[4]) saw = 1'b1;
    end
    r_wr = 1'b0; r_wdata = '0;
    @(negedge r_clk);
    check("R5 doorbell seen", {31'b0, saw}, 1);
    check("R5 final clear", r_rdata, '0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule